// File: doc/BRIEF.md
# Decode-Stage Interlock Stall Generator

This block sits in the decode stage of an in-order, five-stage pipeline with fetch, decode, execute, memory and writeback stages. The pipeline has an integer path and a floating-point path, and the floating-point execute phase lasts four cycles. Each cycle the block sees the instruction in decode: its operation class, its two source register tags and its destination tag. It compares the sources against the destinations of recent older instructions that are still in flight. When a result is not ready yet, it raises a stall and reports how many bubble cycles remain.

The required spacing depends on which class produced the value and which class consumes it, so the block looks it up in a producer-to-consumer latency table. Forwarding paths are assumed to exist, so dependent pairs that the table does not list need no gap.

While a stall is active, upstream keeps fetch and decode unchanged. The block records a bubble, not the held instruction, as the newest in-flight entry. The in-flight history is just deep enough to cover the longest latency in the table.

Top module: `ilk_stall_gen`

## Requirements
- R1: A floating-point ALU result (class code 1) read by a floating-point ALU instruction issued right after it costs 3 stall cycles.
- R2: A floating-point ALU result read by a store (class code 3) issued right after it costs 2 stall cycles.
- R3: A load result (class code 2) read right after it by an integer ALU (class code 0) or floating-point ALU instruction costs 1 stall cycle.
- R4: An integer ALU result read by a branch (class code 4) issued right after it costs 1 stall cycle.
- R5: The following dependent pairs never stall: integer to integer, integer to store, load to store, load to branch, and integer to floating-point.
- R6: A dependency exists only when a source tag equals an in-flight destination tag. Tag 0 never matches.
- R7: While an instruction is held, bubbles_o falls by exactly one per cycle. stall_o is high exactly while bubbles_o is nonzero. issue_o rises in the cycle bubbles_o reaches zero.
- R8: Every cycle between producer and consumer, whether an issued instruction or an empty cycle, removes one cycle from the required stall.
- R9: When several in-flight producers conflict, the stall length is the largest of their remaining latencies.
- R10: Stores and branches write no register. A later source that matches their destination field does not stall. The delay-slot instruction after a branch issues without any stall caused by the branch.
- R11: With dec_valid_i low there is no stall. The cycle enters the history as an empty slot, and the same holds for every stall cycle.
- R12: During reset and right after it, stall_o and bubbles_o are 0 and the history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode stage holds an instruction |
| dec_class_i | input | 3 | Class code: 0 int ALU, 1 FP ALU, 2 load, 3 store, 4 branch |
| dec_dst_i | input | REG_W | Destination tag |
| dec_src_a_i | input | REG_W | First source tag |
| dec_src_b_i | input | REG_W | Second source tag |
| stall_o | output | 1 | Hold fetch and decode, send a bubble to execute |
| bubbles_o | output | CNT_W | Stall cycles still required, including this one |
| issue_o | output | 1 | Decode instruction advances to execute this cycle |

## Verification
The bench uses the default parameters: 5-bit tags and latencies of 3, 2, 1 and 1, which gives a three-deep history and a 2-bit bubble count. This setting makes the full three-cycle floating-point window observable as a countdown from 3 to 1. It also brings the oldest history slot into play, both through an intervening instruction or empty cycle and through two producers of different ages conflicting at once. Reset-time outputs, tag 0 and the non-writing classes are checked at the same settings.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    CLS_INT = 3'd0,
    CLS_FP  = 3'd1,
    CLS_LD  = 3'd2,
    CLS_ST  = 3'd3,
    CLS_BR  = 3'd4
  } op_cls_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic writes_reg(input op_cls_e c);
    return (c == CLS_INT) || (c == CLS_FP) || (c == CLS_LD);
  endfunction

endpackage

// File: rtl/ilk_history.sv
module ilk_history
  import ilk_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int HIST_D = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  op_cls_e                      cls_i,
  input  logic [REG_W-1:0]             dst_i,
  output logic [HIST_D-1:0]            vld_o,
  output op_cls_e                      cls_o [HIST_D],
  output logic [HIST_D-1:0][REG_W-1:0] dst_o
);

  logic [HIST_D-1:0]            vld_q;
  op_cls_e                      cls_q [HIST_D];
  logic [HIST_D-1:0][REG_W-1:0] dst_q;

  // slot 0 is the instruction that left decode most recently
  for (genvar k = 0; k < HIST_D; k++) begin : g_slot
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[0] <= 1'b0;
          cls_q[0] <= CLS_INT;
          dst_q[0] <= '0;
        end else begin
          vld_q[0] <= push_i;
          cls_q[0] <= cls_i;
          dst_q[0] <= dst_i;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[k] <= 1'b0;
          cls_q[k] <= CLS_INT;
          dst_q[k] <= '0;
        end else begin
          vld_q[k] <= vld_q[k-1];
          cls_q[k] <= cls_q[k-1];
          dst_q[k] <= dst_q[k-1];
        end
      end
    end
    assign cls_o[k] = cls_q[k];
  end

  assign vld_o = vld_q;
  assign dst_o = dst_q;

endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
  import ilk_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int AGE        = 0,
  parameter int CNT_W      = 2,
  parameter int LAT_FP_FP  = 3,
  parameter int LAT_FP_ST  = 2,
  parameter int LAT_LD_USE = 1,
  parameter int LAT_INT_BR = 1
) (
  input  logic             valid_i,
  input  op_cls_e          cons_cls_i,
  input  logic [REG_W-1:0] src_a_i,
  input  logic [REG_W-1:0] src_b_i,
  input  logic             prod_vld_i,
  input  op_cls_e          prod_cls_i,
  input  logic [REG_W-1:0] prod_dst_i,
  output logic [CNT_W-1:0] need_o
);

  int   lat;
  logic hit;

  always_comb begin
    lat = 0;
    case (prod_cls_i)
      CLS_FP: begin
        if (cons_cls_i == CLS_FP)      lat = LAT_FP_FP;
        else if (cons_cls_i == CLS_ST) lat = LAT_FP_ST;
      end
      CLS_LD:  if (cons_cls_i == CLS_INT || cons_cls_i == CLS_FP) lat = LAT_LD_USE;
      CLS_INT: if (cons_cls_i == CLS_BR) lat = LAT_INT_BR;
      default: lat = 0;
    endcase
  end

  assign hit = valid_i && prod_vld_i && (prod_dst_i != '0) &&
               ((prod_dst_i == src_a_i) || (prod_dst_i == src_b_i));

  // producer AGE+1 cycles old has lat-AGE cycles left to cover
  assign need_o = (hit && lat > AGE) ? CNT_W'(lat - AGE) : '0;

endmodule

// File: rtl/ilk_max.sv
module ilk_max #(
  parameter int N = 3,
  parameter int W = 2
) (
  input  logic [N-1:0][W-1:0] val_i,
  output logic [W-1:0]        max_o
);

  always_comb begin
    max_o = '0;
    for (int i = 0; i < N; i++) begin
      if (val_i[i] > max_o) max_o = val_i[i];
    end
  end

endmodule

// File: rtl/ilk_stall_gen.sv
module ilk_stall_gen
  import ilk_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int LAT_FP_FP  = 3,
  parameter int LAT_FP_ST  = 2,
  parameter int LAT_LD_USE = 1,
  parameter int LAT_INT_BR = 1,
  localparam int MAX_LAT   = max4(LAT_FP_FP, LAT_FP_ST, LAT_LD_USE, LAT_INT_BR),
  localparam int HIST_D    = (MAX_LAT < 1) ? 1 : MAX_LAT,
  localparam int CNT_W     = $clog2(HIST_D + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_valid_i,
  input  logic [2:0]       dec_class_i,
  input  logic [REG_W-1:0] dec_dst_i,
  input  logic [REG_W-1:0] dec_src_a_i,
  input  logic [REG_W-1:0] dec_src_b_i,
  output logic             stall_o,
  output logic [CNT_W-1:0] bubbles_o,
  output logic             issue_o
);

  op_cls_e                      dec_cls;
  logic                         push;
  logic [HIST_D-1:0]            h_vld;
  op_cls_e                      h_cls [HIST_D];
  logic [HIST_D-1:0][REG_W-1:0] h_dst;
  logic [HIST_D-1:0][CNT_W-1:0] need;

  assign dec_cls = op_cls_e'(dec_class_i);

  ilk_history #(.REG_W(REG_W), .HIST_D(HIST_D)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .cls_i  (dec_cls),
    .dst_i  (dec_dst_i),
    .vld_o  (h_vld),
    .cls_o  (h_cls),
    .dst_o  (h_dst)
  );

  for (genvar k = 0; k < HIST_D; k++) begin : g_cmp
    ilk_hazard #(
      .REG_W(REG_W), .AGE(k), .CNT_W(CNT_W),
      .LAT_FP_FP(LAT_FP_FP), .LAT_FP_ST(LAT_FP_ST),
      .LAT_LD_USE(LAT_LD_USE), .LAT_INT_BR(LAT_INT_BR)
    ) u_haz (
      .valid_i    (dec_valid_i),
      .cons_cls_i (dec_cls),
      .src_a_i    (dec_src_a_i),
      .src_b_i    (dec_src_b_i),
      .prod_vld_i (h_vld[k]),
      .prod_cls_i (h_cls[k]),
      .prod_dst_i (h_dst[k]),
      .need_o     (need[k])
    );
  end

  ilk_max #(.N(HIST_D), .W(CNT_W)) u_max (
    .val_i (need),
    .max_o (bubbles_o)
  );

  assign stall_o = |bubbles_o;
  assign issue_o = dec_valid_i && !stall_o;
  // stalled or empty cycles enter the history as bubbles
  assign push    = issue_o && writes_reg(dec_cls);

  p_idle_no_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |-> !stall_o);

  p_zero_tag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_src_a_i == '0 && dec_src_b_i == '0) |-> !stall_o);

  p_bubble_inject_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !h_vld[0]);

  p_countdown_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stall_o) && $past(bubbles_o) > 1 && dec_valid_i &&
     $stable(dec_class_i) && $stable(dec_src_a_i) && $stable(dec_src_b_i))
    |-> (bubbles_o == CNT_W'($past(bubbles_o) - 1)));

  always_comb begin
    a_bound_r9: assert (int'(bubbles_o) <= MAX_LAT);
  end

endmodule

// File: tb/ilk_stall_gen_test.sv
module ilk_stall_gen_test;

  localparam int REG_W = 5;
  localparam int CW    = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             dec_valid;
  logic [2:0]       dec_class;
  logic [REG_W-1:0] dec_dst, dec_sa, dec_sb;
  logic             stall_o, issue_o;
  logic [CW-1:0]    bubbles_o;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 0;
  int    exp_q[$];
  string req_q[$];

  localparam logic [2:0] C_INT = 3'd0, C_FP = 3'd1, C_LD = 3'd2, C_ST = 3'd3, C_BR = 3'd4;

  always #2 clk = ~clk;  // 250 MHz

  ilk_stall_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dec_valid), .dec_class_i(dec_class),
    .dec_dst_i(dec_dst), .dec_src_a_i(dec_sa), .dec_src_b_i(dec_sb),
    .stall_o(stall_o), .bubbles_o(bubbles_o), .issue_o(issue_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv,
                       input string what);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // driver: present one instruction, hold it until it issues
  task automatic send(input logic [2:0] c, input int d, input int a, input int b,
                      input int exp_stall, input string req);
    @(negedge clk);
    dec_valid = 1'b1;
    dec_class = c;
    dec_dst   = REG_W'(d);
    dec_sa    = REG_W'(a);
    dec_sb    = REG_W'(b);
    exp_q.push_back(exp_stall);
    req_q.push_back(req);
    forever begin
      #1;
      if (issue_o) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      dec_valid = 1'b0;
      dec_sa    = '0;
      dec_sb    = '0;
    end
  endtask

  // monitor: count stall cycles per instruction and compare on issue
  int run = 0;
  int first = 0;
  always @(negedge clk) begin
    #1;
    if (rst_n && dec_valid) begin
      if (run == 0) first = int'(bubbles_o);
      else check(int'(bubbles_o) == first - run, "R7", int'(bubbles_o), first - run,
                 "countdown");
      if (issue_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", 0, 0, "unexpected issue");
        end else begin
          int    e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(first == e, r, first, e, "initial bubbles");
          check(run == e, r, run, e, "stall cycles");
          check(!stall_o, "R7", int'(stall_o), 0, "stall at issue");
        end
        run = 0;
      end else begin
        check(stall_o, "R7", int'(stall_o), 1, "stall while held");
        run++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual 0 expected 1 completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dec_valid = 1'b0; dec_class = C_INT;
    dec_dst = '0; dec_sa = '0; dec_sb = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!stall_o, "R12", int'(stall_o), 0, "stall in reset");
    check(bubbles_o == 0, "R12", int'(bubbles_o), 0, "bubbles in reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R12: empty history after reset
    send(C_FP, 2, 1, 3, 0, "R12");
    idle(4);
    // R1
    send(C_FP, 1, 0, 0, 0, "R1");
    send(C_FP, 2, 1, 0, 3, "R1");
    idle(4);
    // R2
    send(C_FP, 2, 0, 0, 0, "R2");
    send(C_ST, 0, 9, 2, 2, "R2");
    idle(4);
    // R3 integer and FP consumers
    send(C_LD, 3, 0, 0, 0, "R3");
    send(C_INT, 6, 3, 0, 1, "R3");
    idle(4);
    send(C_LD, 4, 0, 0, 0, "R3");
    send(C_FP, 6, 0, 4, 1, "R3");
    idle(4);
    // R4
    send(C_INT, 5, 0, 0, 0, "R4");
    send(C_BR, 0, 5, 0, 1, "R4");
    idle(4);
    // R5 zero-latency pairs
    send(C_INT, 6, 0, 0, 0, "R5");
    send(C_INT, 7, 6, 0, 0, "R5");
    send(C_ST, 0, 0, 7, 0, "R5");
    send(C_LD, 8, 0, 0, 0, "R5");
    send(C_ST, 0, 8, 0, 0, "R5");
    send(C_LD, 9, 0, 0, 0, "R5");
    send(C_BR, 0, 9, 0, 0, "R5");
    send(C_INT, 10, 0, 0, 0, "R5");
    send(C_FP, 11, 10, 0, 0, "R5");
    idle(4);
    // R6 tag 0 and mismatching tags
    send(C_FP, 0, 0, 0, 0, "R6");
    send(C_FP, 12, 0, 0, 0, "R6");
    idle(4);
    send(C_FP, 13, 0, 0, 0, "R6");
    send(C_FP, 14, 15, 16, 0, "R6");
    idle(4);
    // R8 one issued instruction between
    send(C_FP, 9, 0, 0, 0, "R8");
    send(C_INT, 11, 20, 21, 0, "R8");
    send(C_FP, 12, 9, 0, 2, "R8");
    idle(4);
    // R8 one empty cycle between, then two
    send(C_FP, 9, 0, 0, 0, "R8");
    idle(1);
    send(C_FP, 12, 0, 9, 2, "R8");
    idle(4);
    send(C_FP, 9, 0, 0, 0, "R8");
    idle(2);
    send(C_FP, 12, 9, 0, 1, "R8");
    idle(4);
    // R9 two producers: FP two back (2 left), load one back (1 left)
    send(C_FP, 12, 0, 0, 0, "R9");
    send(C_LD, 13, 0, 0, 0, "R9");
    send(C_FP, 14, 12, 13, 2, "R9");
    idle(4);
    // R10 branch delay slot and non-writing classes
    send(C_INT, 14, 0, 0, 0, "R10");
    send(C_BR, 16, 14, 0, 1, "R10");
    send(C_INT, 15, 14, 16, 0, "R10");
    idle(4);
    send(C_ST, 17, 0, 0, 0, "R10");
    send(C_BR, 0, 17, 0, 0, "R10");
    idle(4);
    // R11 invalid decode slot with a matching tag
    send(C_FP, 1, 0, 0, 0, "R11");
    @(negedge clk);
    dec_valid = 1'b0; dec_class = C_FP; dec_sa = 5'd1; dec_sb = 5'd0;
    #1;
    check(!stall_o, "R11", int'(stall_o), 0, "stall when not valid");
    check(bubbles_o == 0, "R11", int'(bubbles_o), 0, "bubbles when not valid");
    // R11 stalled cycles leave bubbles in history: consumer waits only the remainder
    send(C_FP, 3, 1, 0, 2, "R11");
    send(C_ST, 0, 0, 3, 2, "R11");
    idle(4);
    done = 1'b1;
    check(exp_q.size() == 0, "R7", exp_q.size(), 0, "pending items");
    summary();
    $finish;
  end

endmodule